// File: doc/BRIEF.md
# Multi-Channel Register Window Decoder

This block sits between a host register bus and fourteen bus-controller channels that share one 4 KiB address region. Each 32-bit read or write is decoded from its address. An access that lands in a channel's 64-byte window raises that channel's select strobe, together with the byte offset inside the window and the write data. Read data from the selected channel is captured and returned one cycle later.

The windows are not contiguous. The first 64 bytes form a global area. The first group of seven channels follows it. After that group comes a gap reserved for buffer storage, and the second group of seven channels starts after the gap. There is also an unused stretch, and a large buffer area at the top of the region. None of these areas reach any channel. A read of any of them returns all ones.

The global area holds one read-only word: the interrupt summary, with one bit per channel. A single shared interrupt line to the host is driven from that word.

Top module: `rwd_window_decoder`

## Requirements
- R1: A request at byte address A with 0x40 ≤ A < 0x200 selects channel (A>>6)−1 (channels 0..6). Exactly that bit of `ch_sel_o` is set in the request cycle, and `ch_off_o` equals A[5:0].
- R2: A request with 0x300 ≤ A < 0x4C0 selects channel (A>>6)−5 (channels 7..13), with `ch_off_o` equal to A[5:0].
- R3: Requests in 0x200–0x2FF, 0x4C0–0x7FF or 0x800–0xFFF raise no select strobe, and a read there returns 0xFFFF_FFFF.
- R4: A read of global word 0 (A = 0x000..0x003) returns the summary word: bit n is set when channel n is pending, and the upper bits are zero. A read of any other global address (0x004–0x03F) returns 0xFFFF_FFFF.
- R5: A write to the global area raises no select strobe and leaves the summary word unchanged.
- R6: A read request produces `rsp_valid_o` high in the following cycle. `rsp_rdata_o` then holds the value the selected source presented in the request cycle. A write or an idle cycle leaves `rsp_valid_o` low in the following cycle.
- R7: Summary bit n follows `ch_pend_i[n]` with one cycle of latency. It is set when the channel becomes pending and cleared when the channel's pending input returns to zero.
- R8: `irq_o` is the OR of all summary bits, so it stays high while any channel is pending.
- R9: While `rst_ni` is low, the summary word is zero and both `irq_o` and `rsp_valid_o` are low, whatever the inputs are.
- R10: Select strobes are asserted only while `req_valid_i` is high. `ch_wr_o` is high when `req_write_i` is high, and `ch_wdata_o` carries `req_wdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address within the region |
| req_wdata_i | input | 32 | Write data |
| ch_rdata_i | input | 14*32 | Per-channel read data, channel n in bits [32n+31:32n] |
| ch_pend_i | input | 14 | Per-channel interrupt pending |
| ch_sel_o | output | 14 | One-hot channel select strobes |
| ch_wr_o | output | 1 | Write indication to the channels |
| ch_off_o | output | 6 | Byte offset inside the channel window |
| ch_wdata_o | output | 32 | Write data to the channels |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Shared interrupt to the host |

## Verification
On every cycle, the assertions check the following:
- the strobes are one-hot;
- no strobe is raised while idle or for an address outside the channel windows;
- the write flag follows the request;
- a response follows each read and only reads;
- the interrupt line tracks the OR of the previous cycle's pending inputs.

Only the bench's address sweeps can show three things: which channel each window actually reaches, what data each read returns (including the all-ones value in the gap and pool areas), and that a global write leaves the summary word intact. The reset behaviour is also shown only by the bench's scenarios.

// File: rtl/rwd_pkg.sv
package rwd_pkg;
  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_GLOBAL = 2'd1,
    TGT_CHAN   = 2'd2,
    TGT_POOL   = 2'd3
  } tgt_e;
endpackage

// File: rtl/rwd_decode.sv
module rwd_decode
  import rwd_pkg::*;
#(
  parameter int NUM_CH      = 14,
  parameter int NUM_LOW     = 7,
  parameter int GAP_WINS    = 4,
  parameter int POOL_HI_WIN = 32,
  parameter int WIN_W       = 6
) (
  input  logic [WIN_W-1:0]  win_i,
  output logic [NUM_CH-1:0] hit_o,
  output tgt_e              tgt_o
);
  localparam int GAP_LO = NUM_LOW + 1;
  localparam int GAP_HI = GAP_LO + GAP_WINS;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    localparam int BASE = (i < NUM_LOW) ? i + 1 : i + 1 + GAP_WINS;
    assign hit_o[i] = (win_i == WIN_W'(BASE));
  end

  logic in_pool;
  assign in_pool = (int'(win_i) >= GAP_LO && int'(win_i) < GAP_HI) ||
                   (int'(win_i) >= POOL_HI_WIN);

  always_comb begin
    if (win_i == '0)  tgt_o = TGT_GLOBAL;
    else if (|hit_o)  tgt_o = TGT_CHAN;
    else if (in_pool) tgt_o = TGT_POOL;
    else              tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/rwd_status.sv
module rwd_status #(
  parameter int NUM_CH = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pend_i,
  output logic [NUM_CH-1:0] stat_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= pend_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |stat_q;
endmodule

// File: rtl/rwd_rsp.sv
module rwd_rsp
  import rwd_pkg::*;
#(
  parameter int NUM_CH = 14,
  parameter int DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_i,
  input  tgt_e                     tgt_i,
  input  logic                     word0_i,
  input  logic [NUM_CH-1:0]        hit_i,
  input  logic [NUM_CH-1:0]        stat_i,
  input  logic [NUM_CH*DATA_W-1:0] ch_rdata_i,
  output logic                     rsp_valid_o,
  output logic [DATA_W-1:0]        rsp_rdata_o
);
  logic [DATA_W-1:0] chan_d, rd_d;

  always_comb begin
    chan_d = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (hit_i[i]) chan_d = chan_d | ch_rdata_i[i*DATA_W +: DATA_W];
  end

  always_comb begin
    case (tgt_i)
      TGT_GLOBAL: rd_d = word0_i ? DATA_W'(stat_i) : '1;
      TGT_CHAN:   rd_d = chan_d;
      default:    rd_d = '1;  // pool and undecoded space
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_i;
      if (rd_i) rsp_rdata_o <= rd_d;
    end
  end
endmodule

// File: rtl/rwd_window_decoder.sv
module rwd_window_decoder
  import rwd_pkg::*;
#(
  parameter int NUM_CH      = 14,
  parameter int NUM_LOW     = 7,
  parameter int GAP_WINS    = 4,
  parameter int POOL_HI_WIN = 32,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int WIN_LOG2    = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic                     req_write_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  input  logic [NUM_CH*DATA_W-1:0] ch_rdata_i,
  input  logic [NUM_CH-1:0]        ch_pend_i,
  output logic [NUM_CH-1:0]        ch_sel_o,
  output logic                     ch_wr_o,
  output logic [WIN_LOG2-1:0]      ch_off_o,
  output logic [DATA_W-1:0]        ch_wdata_o,
  output logic                     rsp_valid_o,
  output logic [DATA_W-1:0]        rsp_rdata_o,
  output logic                     irq_o
);
  localparam int WIN_W = ADDR_W - WIN_LOG2;

  logic [NUM_CH-1:0] hit, stat;
  tgt_e              tgt;
  logic              word0;

  rwd_decode #(
    .NUM_CH(NUM_CH), .NUM_LOW(NUM_LOW), .GAP_WINS(GAP_WINS),
    .POOL_HI_WIN(POOL_HI_WIN), .WIN_W(WIN_W)
  ) u_dec (
    .win_i (req_addr_i[ADDR_W-1:WIN_LOG2]),
    .hit_o (hit),
    .tgt_o (tgt)
  );

  rwd_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (ch_pend_i),
    .stat_o (stat),
    .irq_o  (irq_o)
  );

  assign word0 = (req_addr_i[WIN_LOG2-1:2] == '0);

  rwd_rsp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (req_valid_i & ~req_write_i),
    .tgt_i       (tgt),
    .word0_i     (word0),
    .hit_i       (hit),
    .stat_i      (stat),
    .ch_rdata_i  (ch_rdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  assign ch_sel_o   = hit & {NUM_CH{req_valid_i}};
  assign ch_wr_o    = req_valid_i & req_write_i;
  assign ch_off_o   = req_addr_i[WIN_LOG2-1:0];
  assign ch_wdata_o = req_wdata_i;
endmodule

// File: rtl/rwd_checker.sv
module rwd_checker #(
  parameter int NUM_CH      = 14,
  parameter int NUM_LOW     = 7,
  parameter int GAP_WINS    = 4,
  parameter int POOL_HI_WIN = 32,
  parameter int WIN_W       = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [WIN_W-1:0]  win_i,
  input logic [NUM_CH-1:0] ch_pend_i,
  input logic [NUM_CH-1:0] ch_sel_o,
  input logic              ch_wr_o,
  input logic              rsp_valid_o,
  input logic              irq_o
);
  localparam int LAST_WIN = NUM_CH + GAP_WINS;
  localparam int GAP_LO   = NUM_LOW + 1;

  logic undecoded;
  assign undecoded = (win_i == '0) || (int'(win_i) > LAST_WIN) ||
                     (int'(win_i) >= GAP_LO && int'(win_i) < GAP_LO + GAP_WINS);

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_sel_o)); // R1
  AST_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> ch_sel_o == '0); // R10
  AST_WR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_sel_o) |-> ch_wr_o == req_write_i); // R10
  AST_UNDEC_NOSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && undecoded) |-> ch_sel_o == '0); // R3
  AST_RD_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o); // R6
  AST_NO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o); // R6
  AST_IRQ_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i || !req_valid_i |=> irq_o == $past(|ch_pend_i)); // R8
endmodule

bind rwd_window_decoder rwd_checker #(
  .NUM_CH(NUM_CH), .NUM_LOW(NUM_LOW), .GAP_WINS(GAP_WINS),
  .POOL_HI_WIN(POOL_HI_WIN), .WIN_W(ADDR_W - WIN_LOG2)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .win_i       (req_addr_i[ADDR_W-1:WIN_LOG2]),
  .ch_pend_i   (ch_pend_i),
  .ch_sel_o    (ch_sel_o),
  .ch_wr_o     (ch_wr_o),
  .rsp_valid_o (rsp_valid_o),
  .irq_o       (irq_o)
);

// File: tb/tb_rwd_window_decoder.sv
`timescale 1ns/1ps
module tb_rwd_window_decoder;
  localparam int NCH = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [11:0]     req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic [NCH*32-1:0] ch_rdata;
  logic [NCH-1:0]  ch_pend = '0;
  logic [NCH-1:0]  ch_sel;
  logic            ch_wr, rsp_valid, irq;
  logic [5:0]      ch_off;
  logic [31:0]     ch_wdata, rsp_rdata;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  // channel n answers {C5, n, 0, offset}
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_rdata[i*32 +: 32] = {8'hC5, 8'(i), 10'h0, ch_off};
  end

  rwd_window_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ch_rdata_i(ch_rdata),
    .ch_pend_i(ch_pend), .ch_sel_o(ch_sel), .ch_wr_o(ch_wr), .ch_off_o(ch_off),
    .ch_wdata_o(ch_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .irq_o(irq)
  );

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // -2 global, -1 nothing, else channel index
  function automatic int exp_chan(input logic [11:0] a);
    int w = int'(a >> 6);
    if (w == 0) return -2;
    if (w >= 1 && w <= 7) return w - 1;
    if (w >= 12 && w <= 18) return w - 5;
    return -1;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a, input logic [NCH-1:0] st);
    int c = exp_chan(a);
    if (c >= 0) return {8'hC5, 8'(c), 10'h0, a[5:0]};
    if (c == -2 && a[5:2] == 4'h0) return {18'h0, st};
    return 32'hFFFF_FFFF;
  endfunction

  function automatic string req_of(input logic [11:0] a);
    int c = exp_chan(a);
    if (c == -2) return "R4";
    if (c < 0) return "R3";
    return (c < 7) ? "R1" : "R2";
  endfunction

  task automatic do_read(input logic [11:0] a, input logic [31:0] exp);
    int c = exp_chan(a);
    logic [NCH-1:0] m = (c >= 0) ? NCH'(1) << c : '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1;
    check(ch_sel == m && (c < 0 || ch_off == a[5:0]) && !ch_wr, req_of(a),
          {ch_wr, 9'h0, ch_off, 2'b0, ch_sel}, {1'b0, 9'h0, a[5:0], 2'b0, m});
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(rsp_valid && rsp_rdata == exp, {req_of(a), "/R6"}, rsp_rdata, exp);
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    int c = exp_chan(a);
    logic [NCH-1:0] m = (c >= 0) ? NCH'(1) << c : '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #1;
    check(ch_sel == m && ch_wr && ch_wdata == d, (c == -2) ? "R5" : "R10",
          {ch_wr, 17'h0, ch_sel}, {1'b1, 17'h0, m});
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    #1;
    check(!rsp_valid && ch_sel == '0, "R6/R10 write", {31'h0, rsp_valid}, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R9: reset holds summary and irq low despite pending inputs
    ch_pend = '1;
    repeat (3) @(negedge clk);
    check(!irq && !rsp_valid, "R9", {30'h0, irq, rsp_valid}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(irq, "R8 after reset", {31'h0, irq}, 32'h1);
    do_read(12'h000, {18'h0, 14'h3FFF});

    // R7/R8: summary patterns
    foreach (ch_pend[k]) begin end
    for (int p = 0; p < 7; p++) begin
      logic [NCH-1:0] pat;
      case (p)
        0: pat = 14'h0000; 1: pat = 14'h0001; 2: pat = 14'h2000;
        3: pat = 14'h2AAA; 4: pat = 14'h1555; 5: pat = 14'h3FFF;
        default: pat = 14'h0000;
      endcase
      @(negedge clk) ch_pend = pat;
      @(negedge clk);
      check(irq == (pat != 0), "R8", {31'h0, irq}, {31'h0, pat != 0});
      do_read(12'h000, {18'h0, pat});
      do_read(12'h002, {18'h0, pat});
    end

    // R7: single-cycle pending pulse sets then clears
    @(negedge clk) ch_pend = 14'h0040;
    @(negedge clk) ch_pend = 14'h0000;
    check(irq, "R7 set", {31'h0, irq}, 32'h1);
    @(negedge clk);
    check(!irq, "R7 clear", {31'h0, irq}, 32'h0);

    // R5: global writes ignored
    @(negedge clk) ch_pend = 14'h0F0F;
    do_write(12'h000, 32'h0);
    do_write(12'h004, 32'hFFFF_FFFF);
    do_write(12'h03C, 32'h1234_5678);
    do_read(12'h000, {18'h0, 14'h0F0F});

    // R1..R4: full read sweep over every word address
    ch_pend = 14'h1A5C;
    @(negedge clk);
    for (int a = 0; a < 4096; a += 4)
      do_read(12'(a), exp_rd(12'(a), 14'h1A5C));
    // byte offsets inside windows
    do_read(12'h043, exp_rd(12'h043, 14'h1A5C));
    do_read(12'h4BF, exp_rd(12'h4BF, 14'h1A5C));
    do_read(12'h1FE, exp_rd(12'h1FE, 14'h1A5C));

    // R10/R3/R5: write sweep
    for (int a = 0; a < 4096; a += 4)
      do_write(12'(a), 32'(a) ^ 32'hA5A5_0000);

    // R9: reset mid-run clears summary
    @(negedge clk) rst_n = 1'b0;
    #1;
    check(!irq && !rsp_valid, "R9 mid-run", {30'h0, irq, rsp_valid}, 32'h0);
    @(negedge clk) ch_pend = '0; rst_n = 1'b1;
    @(negedge clk);
    check(!irq, "R9 release", {31'h0, irq}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule